// File: doc/BRIEF.md
# Paged Memory Clear Engine

This block erases a region of local memory by filling it with a constant byte pattern, working in whole pages. Software writes a start offset and an end offset through a 32-bit register port. Writing the end offset with its trigger bit set launches the clear. The engine widens the requested range outward to page boundaries: the start is rounded down to a page and the end is rounded up to a page. It then drives one full-word write per cycle on a memory write port until the widened range is covered. Two status flags let software poll progress.

The engine is a three-state machine. The states are `ST_IDLE` (waiting for a trigger), `ST_WRITE` (issuing one write per cycle) and `ST_FINISH` (a single cycle used when the widened range is empty). Its transitions are:

- IDLE→WRITE on a trigger when the range is non-empty.
- IDLE→FINISH on a trigger when the range is empty.
- WRITE→WRITE while the word just written is not the last one.
- WRITE→IDLE after the last word.
- FINISH→IDLE unconditionally.

Memory addresses are the offset plus a base-address parameter.

Top module: `mclr_engine`

## Requirements
- R1: After reset the status register (offset 0x20) reads 0, the start and end registers read 0, and `mem_we` is low.
- R2: The start register (offset 0x18) and the end register (offset 0x1C) hold a 22-bit offset in bits 21:0 and read it back. Bits above 21 read 0, including the trigger bit 22 of the end register.
- R3: A write to offset 0x1C with bit 22 set, while idle, gives status bit 0 (pending) = 1 and bit 1 (done) = 0 from the following cycle.
- R4: The first write starts the cycle after the trigger, at address base + (start rounded down to a multiple of 64).
- R5: Writes follow on consecutive cycles with the address stepping by 4. The last write is at base + (end rounded up to a multiple of 64) − 4, so a range yields (ceil64(end) − floor64(start)) / 4 writes.
- R6: Every write carries the data 0x5A5A5A5A.
- R7: The cycle after the last write, `mem_we` is low, pending is 0 and done is 1.
- R8: If ceil64(end) ≤ floor64(start), no write is made: pending is 1 for one cycle, then done is 1.
- R9: A trigger that arrives while a clear is in progress is ignored. The running clear keeps its range and write count.
- R10: A write to offset 0x1C with bit 22 clear updates the end offset but starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |

## Verification
The bench keeps the default 22-bit offset width and 64-byte page, and moves the memory base to 0x8000_0000 so that the base addition is visible on every address. With these values a range near the top of the offset space becomes reachable. There, rounding the end up carries into bit 22, which exercises the extra bit of the limit comparison. The bench also runs unaligned starts and ends, an exact page, reversed and equal offsets that give an empty range, and a second trigger during a 256-word clear.

// File: rtl/mclr_pkg.sv
package mclr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_FINISH = 2'd2
    } mclr_state_e;

    localparam int REG_W = 32;
endpackage

// File: rtl/mclr_regs.sv
module mclr_regs #(
    parameter int             ADDR_W     = 22,
    parameter int             OFF_W      = 8,
    parameter logic [OFF_W-1:0] START_OFF  = 8'h18,
    parameter logic [OFF_W-1:0] END_OFF    = 8'h1C,
    parameter logic [OFF_W-1:0] STATUS_OFF = 8'h20
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [OFF_W-1:0]          reg_addr,
    input  logic [mclr_pkg::REG_W-1:0] reg_wdata,
    input  logic                      pending,
    input  logic                      done,
    output logic [mclr_pkg::REG_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0]         start_q,
    output logic                      trig,
    output logic [ADDR_W-1:0]         trig_end
);
    localparam int TRIG_BIT = ADDR_W;
    localparam int PAD_W    = mclr_pkg::REG_W - ADDR_W;

    logic [ADDR_W-1:0] end_q;
    logic              unused_hi;

    assign unused_hi = ^reg_wdata[mclr_pkg::REG_W-1:TRIG_BIT+1];
    assign trig      = reg_we && (reg_addr == END_OFF) && reg_wdata[TRIG_BIT];
    assign trig_end  = reg_wdata[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (reg_we) begin
            if (reg_addr == START_OFF) start_q <= reg_wdata[ADDR_W-1:0];
            if (reg_addr == END_OFF)   end_q   <= reg_wdata[ADDR_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == START_OFF)       reg_rdata = {{PAD_W{1'b0}}, start_q};
        else if (reg_addr == END_OFF)    reg_rdata = {{PAD_W{1'b0}}, end_q};
        else if (reg_addr == STATUS_OFF) reg_rdata = {{(mclr_pkg::REG_W-2){1'b0}}, done, pending};
    end
endmodule

// File: rtl/mclr_range.sv
module mclr_range #(
    parameter int ADDR_W     = 22,
    parameter int PAGE_BYTES = 64
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic [ADDR_W:0]   first,
    output logic [ADDR_W:0]   limit,
    output logic              empty
);
    localparam logic [ADDR_W:0] PAGE_M1 = (ADDR_W+1)'(PAGE_BYTES - 1);
    localparam logic [ADDR_W:0] MASK    = ~PAGE_M1;

    assign first = {1'b0, start_addr} & MASK;
    assign limit = ({1'b0, end_addr} + PAGE_M1) & MASK;
    assign empty = (limit <= first);
endmodule

// File: rtl/mclr_fsm.sv
module mclr_fsm #(
    parameter int ADDR_W     = 22,
    parameter int PAGE_BYTES = 64,
    parameter int WORD_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig,
    input  logic [ADDR_W:0] first,
    input  logic [ADDR_W:0] limit,
    input  logic            empty,
    output logic [ADDR_W:0] cur_q,
    output logic            we,
    output logic            pending,
    output logic            done
);
    import mclr_pkg::*;

    localparam int              PAGE_LSB = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W:0] STEP     = (ADDR_W+1)'(WORD_BYTES);

    mclr_state_e     state_q, state_d;
    logic [ADDR_W:0] lim_q;
    logic            last;

    assign last = (cur_q + STEP) >= lim_q;
    assign we   = (state_q == ST_WRITE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (trig) state_d = empty ? ST_FINISH : ST_WRITE;
            ST_WRITE:  if (last) state_d = ST_IDLE;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            lim_q   <= '0;
            pending <= 1'b0;
            done    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (trig) begin
                    cur_q   <= first;
                    lim_q   <= limit;
                    pending <= 1'b1;
                    done    <= 1'b0;
                end
                ST_WRITE: begin
                    cur_q <= cur_q + STEP;
                    if (last) begin
                        pending <= 1'b0;
                        done    <= 1'b1;
                    end
                end
                ST_FINISH: begin
                    pending <= 1'b0;
                    done    <= 1'b1;
                end
                default: pending <= 1'b0;
            endcase
        end
    end

    AST_WE_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n) we |-> pending) else $error("write without pending"); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (we && $past(we)) |-> (cur_q == $past(cur_q) + STEP)) else $error("address step"); // R5
    AST_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) we |-> (cur_q < lim_q)) else $error("write past limit"); // R5
    AST_FIRST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) $rose(we) |-> (cur_q[PAGE_LSB-1:0] == '0)) else $error("unaligned first write"); // R4
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(pending && done)) else $error("pending and done together"); // R7
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(pending) |-> done) else $error("pending fell without done"); // R7
    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(pending) |-> !done) else $error("done left set on start"); // R3
endmodule

// File: rtl/mclr_engine.sv
module mclr_engine #(
    parameter int                ADDR_W     = 22,
    parameter int                OFF_W      = 8,
    parameter int                PAGE_BYTES = 64,
    parameter int                WORD_BYTES = 4,
    parameter int                MEM_ADDR_W = 32,
    parameter logic [MEM_ADDR_W-1:0] MEM_BASE = '0,
    parameter logic [7:0]        FILL_BYTE  = 8'h5A,
    parameter logic [OFF_W-1:0]  START_OFF  = 8'h18,
    parameter logic [OFF_W-1:0]  END_OFF    = 8'h1C,
    parameter logic [OFF_W-1:0]  STATUS_OFF = 8'h20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [OFF_W-1:0]        reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic                    mem_we,
    output logic [MEM_ADDR_W-1:0]   mem_addr,
    output logic [WORD_BYTES*8-1:0] mem_wdata
);
    logic [ADDR_W-1:0] start_q, trig_end;
    logic [ADDR_W:0]   first, limit, cur_q;
    logic              trig, empty, pending, done;

    mclr_regs #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W),
        .START_OFF(START_OFF), .END_OFF(END_OFF), .STATUS_OFF(STATUS_OFF)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pending(pending), .done(done),
        .reg_rdata(reg_rdata), .start_q(start_q), .trig(trig), .trig_end(trig_end)
    );

    mclr_range #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_range (
        .start_addr(start_q), .end_addr(trig_end),
        .first(first), .limit(limit), .empty(empty)
    );

    mclr_fsm #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(WORD_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .trig(trig), .first(first), .limit(limit),
        .empty(empty), .cur_q(cur_q), .we(mem_we), .pending(pending), .done(done)
    );

    assign mem_addr  = MEM_BASE + MEM_ADDR_W'(cur_q);
    assign mem_wdata = {WORD_BYTES{FILL_BYTE}};
endmodule

// File: tb/mclr_engine_bench.sv
module mclr_engine_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h8000_0000;
    localparam logic [7:0]  OFF_START  = 8'h18;
    localparam logic [7:0]  OFF_END    = 8'h1C;
    localparam logic [7:0]  OFF_STAT   = 8'h20;
    localparam int          TRIG       = 32'h0040_0000;

    logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = OFF_STAT;
    logic [31:0] reg_wdata = '0, reg_rdata, mem_addr, mem_wdata;
    logic        mem_we;

    mclr_engine #(.MEM_BASE(BASE)) u_mclr_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0, wcnt = 0;
    int q[$];
    bit m_busy = 0, m_pend = 0, m_done = 0;
    int m_start = 0;

    function automatic int pfloor(int a); return a & ~63; endfunction
    function automatic int pceil(int a);  return (a + 63) & ~63; endfunction
    function automatic int nwords(int s, int e);
        return (pceil(e) > pfloor(s)) ? (pceil(e) - pfloor(s)) / 4 : 0;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model, advanced on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_busy = 0; m_pend = 0; m_done = 0; m_start = 0;
        end else begin
            if (m_busy) begin
                if (q.size() > 0) void'(q.pop_front());
                if (q.size() == 0) begin m_busy = 0; m_pend = 0; m_done = 1; end
            end else if (reg_we && reg_addr == OFF_END && reg_wdata[22]) begin
                q.delete();
                for (int a = pfloor(m_start); a < pceil(int'(reg_wdata[21:0])); a += 4) q.push_back(a);
                m_busy = 1; m_pend = 1; m_done = 0;
            end
            if (reg_we && reg_addr == OFF_START) m_start = int'(reg_wdata[21:0]);
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) wcnt++;
            chk("R5 R8 R9", "mem_we", 64'(mem_we), 64'(m_busy && q.size() > 0));
            if (mem_we && q.size() > 0) begin
                chk("R4 R5", "mem_addr", 64'(mem_addr), 64'(BASE + 32'(q[0])));
                chk("R6", "mem_wdata", 64'(mem_wdata), 64'h5A5A5A5A);
            end
            if (!reg_we && reg_addr == OFF_STAT)
                chk("R3 R7", "status", 64'(reg_rdata), 64'({m_done, m_pend}));
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = OFF_STAT;
    endtask

    task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
        @(posedge clk); #1;
        reg_addr = a; #2;
        chk(req, "read", 64'(reg_rdata), 64'(exp));
        reg_addr = OFF_STAT;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (m_busy && t < 5000) begin @(posedge clk); t++; end
        if (m_busy) chk("R7", "timeout waiting for done", 64'd1, 64'd0);
        @(posedge clk); #1;
    endtask

    task automatic run_op(string req, int s, int e);
        wr(OFF_START, 32'(s));
        wcnt = 0;
        wr(OFF_END, 32'(e) | TRIG);
        #1 chk("R3", "status after trigger", 64'(reg_rdata), 64'h1);
        wait_idle();
        chk(req, "write count", 64'(wcnt), 64'(nwords(s, e)));
        #1 chk("R7", "status after completion", 64'(reg_rdata), 64'h2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk("R7", "watchdog expired", 64'd1, 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 chk("R1", "mem_we in reset", 64'(mem_we), 64'd0);
        rst_n = 1'b1;
        rd("R1", OFF_STAT, 32'h0);
        rd("R1", OFF_START, 32'h0);
        rd("R1", OFF_END, 32'h0);

        // R2 readback, R10 no start without bit 22
        wr(OFF_START, 32'hFFC0_0123);
        rd("R2", OFF_START, 32'h0000_0123);
        wcnt = 0;
        wr(OFF_END, 32'h0000_01FF);
        repeat (5) @(posedge clk);
        #1 chk("R10", "no writes without trigger", 64'(wcnt), 64'd0);
        rd("R10", OFF_STAT, 32'h0);
        rd("R2", OFF_END, 32'h0000_01FF);

        run_op("R5", 32'h123, 32'h1FF);          // 64 words
        rd("R2", OFF_END, 32'h0000_01FF);        // trigger bit reads 0
        run_op("R4 R5", 32'h40, 32'h80);         // exact single page
        run_op("R5", 32'h90, 32'h81);            // both snap into one page
        run_op("R8", 32'h80, 32'h80);            // empty, equal
        run_op("R8", 32'h200, 32'h100);          // empty, reversed
        run_op("R8", 32'h0, 32'h0);              // empty at zero
        run_op("R4 R5", 32'h3FFFC5, 32'h3FFFFF); // top page, ceiling carries

        // R9: second trigger while busy is ignored
        wr(OFF_START, 32'h0);
        wcnt = 0;
        wr(OFF_END, 32'h3FF | TRIG);
        repeat (10) @(posedge clk);
        wr(OFF_START, 32'h1000);
        wr(OFF_END, 32'h40 | TRIG);
        wait_idle();
        chk("R9", "write count with ignored trigger", 64'(wcnt), 64'(nwords(0, 32'h3FF)));
        rd("R9", OFF_STAT, 32'h2);

        repeat (3) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule